// File: doc/BRIEF.md
# Compressed Instruction Expander (RV64, base compressed subset)

This block turns a 16-bit compressed instruction parcel for a 64-bit RISC-V core into the 32-bit base-ISA word that does the same thing. It sorts each parcel by quadrant and function code, gathers the scattered immediate bits, sign-extends them where the encoding is signed, and widens the 3-bit compact register fields. Every reserved encoding is reported through an explicit illegal flag rather than being guessed at. Words whose low two bits are `11` are already full length. They pass through unchanged and are marked as not compressed.

Parcels enter on a valid/ready input and leave from one output register on a valid/ready output. A parcel is taken on any clock edge where `in_valid` and `in_ready` are both high. Its expansion is visible on the next cycle. While `out_valid` is high and `out_ready` is low, the output holds still and `in_ready` stays low, so back-pressure reaches the source in the same cycle. When the consumer takes the held word, a new parcel can be accepted on that same edge.

Top module: `rvc_expander`

## Requirements
- R1: A synchronous active-high reset clears `out_valid`. While the output is empty, `in_ready` is 1.
- R2: `in_ready` equals `!out_valid || out_ready`. An accepted parcel appears on the outputs one cycle later. While `out_valid && !out_ready`, the output word and flags stay unchanged.
- R3: An input whose bits [1:0] are `11` is output unchanged, with `out_wide`=1 and `out_illegal`=0. For compressed parcels, input bits [31:16] are ignored and `out_wide` is 0.
- R4: A compact register field f selects register x(8+f). Quadrant 00 word and doubleword loads and stores expand to lw/ld/sw/sd (funct3 010/011) with a zero-extended scaled offset, the base at bits [9:7] and the data register at [4:2].
- R5: Quadrant 00, function 000 expands to addi rd', x2, nzuimm. A zero nzuimm is illegal, and this includes the all-zero parcel.
- R6: Quadrant 01 functions 000, 001 and 010 expand to addi rd,rd / addiw rd,rd / addi rd,x0 with a sign-extended 6-bit immediate. Function 001 with rd=x0 is illegal. Function 100 with sub-selector 00/01/10 expands to srli/srai/andi on rd' (6-bit shift amount, sign-extended andi immediate).
- R7: Quadrant 01, function 011 with rd=x2 expands to addi x2,x2,imm, where imm is a sign-extended multiple of 16 and must be nonzero. With any other rd it expands to lui rd with a sign-extended 6-bit upper immediate. It is illegal when that immediate is zero or rd=x0.
- R8: The quadrant 01 register-register group expands to sub/xor/or/and (bit 12 = 0, bits [6:5] = 00..11) on the OP opcode, or to subw/addw (bit 12 = 1, bits [6:5] = 00/01) on the OP-32 opcode. Selectors 10/11 with bit 12 = 1 are illegal.
- R9: Quadrant 01 function 101 expands to jal x0 with a sign-extended 12-bit offset. Functions 110/111 expand to beq/bne rs1', x0 with a sign-extended 9-bit offset.
- R10: Quadrant 10 expands function 000 to slli rd,rd,shamt6. Functions 010/011 expand to lw/ld rd from x2, and are illegal when rd=x0. Functions 110/111 expand to sw/sd from x2, with a zero-extended scaled offset.
- R11: Quadrant 10 function 100 expands as follows: jr to jalr x0,0(rs1), illegal when rs1=x0; mv to add rd,x0,rs2; ebreak to 0x00100073; jalr to jalr x1,0(rs1); add to add rd,rd,rs2.
- R12: Illegal compressed parcels give `out_illegal`=1 and an all-zero word. Unlisted function codes are illegal: quadrant 00 codes 001/100/101 and quadrant 10 codes 001/101.
- R13: Every legal output word has bits [1:0] = `11`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input parcel valid |
| in_ready | output | 1 | Block can accept a parcel this cycle |
| in_word | input | 32 | Parcel in bits [15:0], or a full 32-bit word when bits [1:0] are `11` |
| out_valid | output | 1 | Output register holds a result |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_word | output | 32 | Expanded 32-bit instruction, or zero when illegal |
| out_illegal | output | 1 | Parcel is reserved or undefined |
| out_wide | output | 1 | Input was already a 32-bit word |

## Verification
Every one of the 49,152 compressed parcel values is streamed back to back, with junk in the upper input half. Each result is compared against an arithmetic model that builds offsets as integers and then encodes them. This sweep separates misplaced immediate bits, wrong sign extension, wrong compact register offset and every reserved-versus-legal boundary, including the zero-immediate, x0 and x2 cases. A separate sweep of full-length words shows that pass-through leaves them untouched. A stall test holds the consumer off while a second parcel waits, which separates a register that holds correctly from one that overwrites or drops a word. A reset taken mid-stream shows the valid bit clearing.

// File: rtl/rvc_pkg.sv
package rvc_pkg;
  localparam int PARCEL_W = 16;
  localparam int WORD_W   = 32;
  localparam int REG_W    = 5;

  localparam logic [6:0] OPC_LOAD  = 7'h03;
  localparam logic [6:0] OPC_IMM   = 7'h13;
  localparam logic [6:0] OPC_IMM32 = 7'h1b;
  localparam logic [6:0] OPC_STORE = 7'h23;
  localparam logic [6:0] OPC_OP    = 7'h33;
  localparam logic [6:0] OPC_LUI   = 7'h37;
  localparam logic [6:0] OPC_OP32  = 7'h3b;
  localparam logic [6:0] OPC_BR    = 7'h63;
  localparam logic [6:0] OPC_JALR  = 7'h67;
  localparam logic [6:0] OPC_JAL   = 7'h6f;
  localparam logic [WORD_W-1:0] BREAK_WORD = 32'h0010_0073;
  localparam logic [6:0] F7_ALT    = 7'b0100000;

  localparam logic [REG_W-1:0] X0 = 5'd0;
  localparam logic [REG_W-1:0] X1 = 5'd1;
  localparam logic [REG_W-1:0] X2 = 5'd2;

  // immediates pre-built per format, already sized for their target field
  typedef struct packed {
    logic [11:0] ciw;
    logic [11:0] wofs;
    logic [11:0] dofs;
    logic [11:0] i6;
    logic [11:0] sh;
    logic [11:0] sp16;
    logic [19:0] up;
    logic [12:0] br;
    logic [20:0] jo;
    logic [11:0] lwsp;
    logic [11:0] ldsp;
    logic [11:0] swsp;
    logic [11:0] sdsp;
  } rvc_imms_t;

  function automatic logic [31:0] enc_i(logic [11:0] imm, logic [4:0] rs1,
                                        logic [2:0] f3, logic [4:0] rd, logic [6:0] op);
    return {imm, rs1, f3, rd, op};
  endfunction

  function automatic logic [31:0] enc_s(logic [11:0] imm, logic [4:0] rs2,
                                        logic [4:0] rs1, logic [2:0] f3);
    return {imm[11:5], rs2, rs1, f3, imm[4:0], OPC_STORE};
  endfunction

  function automatic logic [31:0] enc_b(logic [12:1] imm, logic [4:0] rs1, logic [2:0] f3);
    return {imm[12], imm[10:5], X0, rs1, f3, imm[4:1], imm[11], OPC_BR};
  endfunction

  function automatic logic [31:0] enc_j(logic [20:1] imm);
    return {imm[20], imm[10:1], imm[11], imm[19:12], X0, OPC_JAL};
  endfunction

  function automatic logic [31:0] enc_r(logic [6:0] f7, logic [4:0] rs2, logic [4:0] rs1,
                                        logic [2:0] f3, logic [4:0] rd, logic [6:0] op);
    return {f7, rs2, rs1, f3, rd, op};
  endfunction

  function automatic logic [2:0] alu_f3(logic [1:0] sel);
    case (sel)
      2'b00:   return 3'b000;
      2'b01:   return 3'b100;
      2'b10:   return 3'b110;
      default: return 3'b111;
    endcase
  endfunction
endpackage

// File: rtl/rvc_imm.sv
module rvc_imm
  import rvc_pkg::*;
(
  input  logic [12:2] b,
  output rvc_imms_t   im
);
  always_comb begin
    im.ciw  = {2'b00, b[10:7], b[12:11], b[5], b[6], 2'b00};
    im.wofs = {5'b0, b[5], b[12:10], b[6], 2'b00};
    im.dofs = {4'b0, b[6:5], b[12:10], 3'b000};
    im.i6   = {{6{b[12]}}, b[12], b[6:2]};
    im.sh   = {6'b0, b[12], b[6:2]};
    im.sp16 = {{3{b[12]}}, b[4:3], b[5], b[2], b[6], 4'b0000};
    im.up   = {{14{b[12]}}, b[12], b[6:2]};
    im.br   = {{5{b[12]}}, b[6:5], b[2], b[11:10], b[4:3], 1'b0};
    im.jo   = {{10{b[12]}}, b[8], b[10:9], b[6], b[7], b[2], b[11], b[5:3], 1'b0};
    im.lwsp = {4'b0, b[3:2], b[12], b[6:4], 2'b00};
    im.ldsp = {3'b0, b[4:2], b[12], b[6:5], 3'b000};
    im.swsp = {4'b0, b[8:7], b[12:9], 2'b00};
    im.sdsp = {3'b0, b[9:7], b[12:10], 3'b000};
  end
endmodule

// File: rtl/rvc_decode.sv
module rvc_decode
  import rvc_pkg::*;
(
  input  logic [WORD_W-1:0] in_word,
  output logic [WORD_W-1:0] dec_word,
  output logic              dec_illegal,
  output logic              dec_wide
);
  localparam int FIELD_W = 3;

  rvc_imms_t im;
  logic [1:0]         quad;
  logic [2:0]         fn;
  logic [REG_W-1:0]   rf, r2, rcd, rcs;
  logic [WORD_W-1:0]  w;
  logic               bad;

  assign quad = in_word[1:0];
  assign fn   = in_word[15:13];
  assign rf   = in_word[11:7];
  assign r2   = in_word[6:2];
  assign rcd  = {2'b01, in_word[7 +: FIELD_W]};
  assign rcs  = {2'b01, in_word[2 +: FIELD_W]};

  rvc_imm u_imm (.b(in_word[12:2]), .im(im));

  always_comb begin
    w    = '0;
    bad  = 1'b0;
    dec_wide = 1'b0;
    case (quad)
      2'b00: case (fn)
        3'b000: begin
          bad = (im.ciw == '0);
          w   = enc_i(im.ciw, X2, 3'b000, rcs, OPC_IMM);
        end
        3'b010: w = enc_i(im.wofs, rcd, 3'b010, rcs, OPC_LOAD);
        3'b011: w = enc_i(im.dofs, rcd, 3'b011, rcs, OPC_LOAD);
        3'b110: w = enc_s(im.wofs, rcs, rcd, 3'b010);
        3'b111: w = enc_s(im.dofs, rcs, rcd, 3'b011);
        default: bad = 1'b1;
      endcase
      2'b01: case (fn)
        3'b000: w = enc_i(im.i6, rf, 3'b000, rf, OPC_IMM);
        3'b001: begin
          bad = (rf == X0);
          w   = enc_i(im.i6, rf, 3'b000, rf, OPC_IMM32);
        end
        3'b010: w = enc_i(im.i6, X0, 3'b000, rf, OPC_IMM);
        3'b011: begin
          if (rf == X2) begin
            bad = (im.sp16 == '0);
            w   = enc_i(im.sp16, X2, 3'b000, X2, OPC_IMM);
          end else begin
            bad = (rf == X0) || (im.sh == '0);
            w   = {im.up, rf, OPC_LUI};
          end
        end
        3'b100: case (in_word[11:10])
          2'b00: w = enc_i(im.sh, rcd, 3'b101, rcd, OPC_IMM);
          2'b01: w = enc_i(im.sh | 12'h400, rcd, 3'b101, rcd, OPC_IMM);
          2'b10: w = enc_i(im.i6, rcd, 3'b111, rcd, OPC_IMM);
          default: begin
            if (!in_word[12])
              w = enc_r((in_word[6:5] == 2'b00) ? F7_ALT : 7'd0, rcs, rcd,
                        alu_f3(in_word[6:5]), rcd, OPC_OP);
            else if (!in_word[6])
              w = enc_r(in_word[5] ? 7'd0 : F7_ALT, rcs, rcd, 3'b000, rcd, OPC_OP32);
            else
              bad = 1'b1;
          end
        endcase
        3'b101: w = enc_j(im.jo[20:1]);
        3'b110: w = enc_b(im.br[12:1], rcd, 3'b000);
        default: w = enc_b(im.br[12:1], rcd, 3'b001);
      endcase
      2'b10: case (fn)
        3'b000: w = enc_i(im.sh, rf, 3'b001, rf, OPC_IMM);
        3'b010: begin
          bad = (rf == X0);
          w   = enc_i(im.lwsp, X2, 3'b010, rf, OPC_LOAD);
        end
        3'b011: begin
          bad = (rf == X0);
          w   = enc_i(im.ldsp, X2, 3'b011, rf, OPC_LOAD);
        end
        3'b100: begin
          if (!in_word[12]) begin
            if (r2 == X0) begin
              bad = (rf == X0);
              w   = enc_i(12'd0, rf, 3'b000, X0, OPC_JALR);
            end else begin
              w = enc_r(7'd0, r2, X0, 3'b000, rf, OPC_OP);
            end
          end else if (r2 == X0) begin
            w = (rf == X0) ? BREAK_WORD : enc_i(12'd0, rf, 3'b000, X1, OPC_JALR);
          end else begin
            w = enc_r(7'd0, r2, rf, 3'b000, rf, OPC_OP);
          end
        end
        3'b110: w = enc_s(im.swsp, r2, X2, 3'b010);
        3'b111: w = enc_s(im.sdsp, r2, X2, 3'b011);
        default: bad = 1'b1;
      endcase
      default: begin
        w        = in_word;
        dec_wide = 1'b1;
      end
    endcase
  end

  assign dec_illegal = bad;
  assign dec_word    = bad ? '0 : w;
endmodule

// File: rtl/rvc_stage.sv
module rvc_stage #(
  parameter int DW = 34
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          up_valid,
  output logic          up_ready,
  input  logic [DW-1:0] up_data,
  output logic          dn_valid,
  input  logic          dn_ready,
  output logic [DW-1:0] dn_data
);
  logic          v_q;
  logic [DW-1:0] d_q;

  assign up_ready = !v_q || dn_ready;

  always_ff @(posedge clk) begin
    if (rst)           v_q <= 1'b0;
    else if (up_ready) v_q <= up_valid;
  end

  always_ff @(posedge clk) begin
    if (up_valid && up_ready) d_q <= up_data;
  end

  assign dn_valid = v_q;
  assign dn_data  = d_q;
endmodule

// File: rtl/rvc_expander.sv
module rvc_expander
  import rvc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_word,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_word,
  output logic              out_illegal,
  output logic              out_wide
);
  localparam int PAY_W = WORD_W + 2;

  logic [WORD_W-1:0] dec_word;
  logic              dec_illegal, dec_wide;
  logic [PAY_W-1:0]  q_data;

  rvc_decode u_dec (
    .in_word(in_word), .dec_word(dec_word),
    .dec_illegal(dec_illegal), .dec_wide(dec_wide)
  );

  rvc_stage #(.DW(PAY_W)) u_stage (
    .clk(clk), .rst(rst),
    .up_valid(in_valid), .up_ready(in_ready),
    .up_data({dec_wide, dec_illegal, dec_word}),
    .dn_valid(out_valid), .dn_ready(out_ready), .dn_data(q_data)
  );

  assign out_word    = q_data[WORD_W-1:0];
  assign out_illegal = q_data[WORD_W];
  assign out_wide    = q_data[WORD_W+1];

  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_word) && $stable(out_illegal) && $stable(out_wide));

  p_take_r2: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready |=> out_valid);

  p_stall_r2: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |-> !in_ready);

  p_zero_word_r12: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_illegal |-> out_word == '0);

  p_wide_legal_r3: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_wide |-> !out_illegal && out_word[1:0] == 2'b11);

  p_full_length_r13: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_illegal |-> out_word[1:0] == 2'b11);
endmodule

// File: tb/sim_rvc_expander.sv
module sim_rvc_expander;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_word = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_word;
  logic        out_illegal;
  logic        out_wide;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  rvc_expander u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_word(in_word),
    .out_valid(out_valid), .out_ready(out_ready), .out_word(out_word),
    .out_illegal(out_illegal), .out_wide(out_wide)
  );

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int gb(logic [15:0] p, int h, int l);
    return int'((p >> l) & 16'((1 << (h - l + 1)) - 1));
  endfunction

  function automatic int sx(int v, int n);
    return (v ^ (1 << (n - 1))) - (1 << (n - 1));
  endfunction

  function automatic logic [31:0] ei(int imm, int rs1, int f3, int rd, int op);
    return (32'(imm & 4095) << 20) | (32'(rs1) << 15) | (32'(f3) << 12) | (32'(rd) << 7) | 32'(op);
  endfunction

  function automatic logic [31:0] es(int imm, int rs2, int rs1, int f3);
    return (32'((imm >> 5) & 127) << 25) | (32'(rs2) << 20) | (32'(rs1) << 15) |
           (32'(f3) << 12) | (32'(imm & 31) << 7) | 32'h23;
  endfunction

  function automatic logic [31:0] eb(int imm, int rs1, int f3);
    return (32'((imm >> 12) & 1) << 31) | (32'((imm >> 5) & 63) << 25) | (32'(rs1) << 15) |
           (32'(f3) << 12) | (32'((imm >> 1) & 15) << 8) | (32'((imm >> 11) & 1) << 7) | 32'h63;
  endfunction

  function automatic logic [31:0] ej(int imm);
    return (32'((imm >> 20) & 1) << 31) | (32'((imm >> 1) & 1023) << 21) |
           (32'((imm >> 11) & 1) << 20) | (32'((imm >> 12) & 255) << 12) | 32'h6f;
  endfunction

  function automatic logic [31:0] er(int f7, int rs2, int rs1, int f3, int rd, int op);
    return (32'(f7) << 25) | (32'(rs2) << 20) | (32'(rs1) << 15) | (32'(f3) << 12) |
           (32'(rd) << 7) | 32'(op);
  endfunction

  // arithmetic reference model
  task automatic ref_exp(input logic [15:0] p, output logic [31:0] w, output bit ill,
                         output string tag);
    int q, f, rd, r2, rc, rl, i6, sh, v;
    q  = gb(p, 1, 0);  f = gb(p, 15, 13);
    rd = gb(p, 11, 7); r2 = gb(p, 6, 2);
    rc = 8 + gb(p, 9, 7); rl = 8 + gb(p, 4, 2);
    sh = gb(p, 12, 12) * 32 + gb(p, 6, 2);
    i6 = sx(sh, 6);
    ill = 1'b0; w = '0; tag = "R12";
    if (q == 0) begin
      case (f)
        0: begin
          v = gb(p, 10, 7) * 64 + gb(p, 12, 11) * 16 + gb(p, 5, 5) * 8 + gb(p, 6, 6) * 4;
          tag = "R5";
          if (v == 0) ill = 1'b1; else w = ei(v, 2, 0, rl, 'h13);
        end
        2: begin tag = "R4"; w = ei(gb(p,12,10)*8 + gb(p,6,6)*4 + gb(p,5,5)*64, rc, 2, rl, 'h03); end
        3: begin tag = "R4"; w = ei(gb(p,12,10)*8 + gb(p,6,5)*64, rc, 3, rl, 'h03); end
        6: begin tag = "R4"; w = es(gb(p,12,10)*8 + gb(p,6,6)*4 + gb(p,5,5)*64, rl, rc, 2); end
        7: begin tag = "R4"; w = es(gb(p,12,10)*8 + gb(p,6,5)*64, rl, rc, 3); end
        default: ill = 1'b1;
      endcase
    end else if (q == 1) begin
      case (f)
        0: begin tag = "R6"; w = ei(i6, rd, 0, rd, 'h13); end
        1: begin tag = "R6"; if (rd == 0) ill = 1'b1; else w = ei(i6, rd, 0, rd, 'h1b); end
        2: begin tag = "R6"; w = ei(i6, 0, 0, rd, 'h13); end
        3: begin
          tag = "R7";
          if (rd == 2) begin
            v = gb(p,12,12)*512 + gb(p,4,3)*128 + gb(p,5,5)*64 + gb(p,2,2)*32 + gb(p,6,6)*16;
            if (v == 0) ill = 1'b1; else w = ei(sx(v, 10), 2, 0, 2, 'h13);
          end else if (rd == 0 || sh == 0) ill = 1'b1;
          else w = (32'(i6 & 'hfffff) << 12) | (32'(rd) << 7) | 32'h37;
        end
        4: begin
          case (gb(p, 11, 10))
            0: begin tag = "R6"; w = ei(sh, rc, 5, rc, 'h13); end
            1: begin tag = "R6"; w = ei(sh + 1024, rc, 5, rc, 'h13); end
            2: begin tag = "R6"; w = ei(i6, rc, 7, rc, 'h13); end
            default: begin
              tag = "R8";
              v = gb(p, 6, 5);
              if (gb(p, 12, 12) == 0)
                w = er(v == 0 ? 32 : 0, rl, rc, v == 0 ? 0 : v == 1 ? 4 : v == 2 ? 6 : 7, rc, 'h33);
              else if (v == 0) w = er(32, rl, rc, 0, rc, 'h3b);
              else if (v == 1) w = er(0, rl, rc, 0, rc, 'h3b);
              else ill = 1'b1;
            end
          endcase
        end
        5: begin
          tag = "R9";
          v = gb(p,12,12)*2048 + gb(p,8,8)*1024 + gb(p,10,9)*256 + gb(p,6,6)*128 +
              gb(p,7,7)*64 + gb(p,2,2)*32 + gb(p,11,11)*16 + gb(p,5,3)*2;
          w = ej(sx(v, 12));
        end
        default: begin
          tag = "R9";
          v = gb(p,12,12)*256 + gb(p,6,5)*64 + gb(p,2,2)*32 + gb(p,11,10)*8 + gb(p,4,3)*2;
          w = eb(sx(v, 9), rc, f == 6 ? 0 : 1);
        end
      endcase
    end else begin
      case (f)
        0: begin tag = "R10"; w = ei(sh, rd, 1, rd, 'h13); end
        2: begin tag = "R10";
          if (rd == 0) ill = 1'b1;
          else w = ei(gb(p,12,12)*32 + gb(p,6,4)*4 + gb(p,3,2)*64, 2, 2, rd, 'h03); end
        3: begin tag = "R10";
          if (rd == 0) ill = 1'b1;
          else w = ei(gb(p,12,12)*32 + gb(p,6,5)*8 + gb(p,4,2)*64, 2, 3, rd, 'h03); end
        4: begin
          tag = "R11";
          if (gb(p, 12, 12) == 0) begin
            if (r2 == 0) begin if (rd == 0) ill = 1'b1; else w = ei(0, rd, 0, 0, 'h67); end
            else w = er(0, r2, 0, 0, rd, 'h33);
          end else if (r2 == 0) begin
            w = (rd == 0) ? 32'h0010_0073 : ei(0, rd, 0, 1, 'h67);
          end else w = er(0, r2, rd, 0, rd, 'h33);
        end
        6: begin tag = "R10"; w = es(gb(p,12,9)*4 + gb(p,8,7)*64, r2, 2, 2); end
        7: begin tag = "R10"; w = es(gb(p,12,10)*8 + gb(p,9,7)*64, r2, 2, 3); end
        default: ill = 1'b1;
      endcase
    end
    if (ill) begin w = '0; tag = {tag, "/R12"}; end
  endtask

  task automatic chk_out(logic [31:0] ew, bit eill, bit ewide, string tag);
    chk(out_valid && out_word == ew && out_illegal == eill && out_wide == ewide,
        tag, {out_valid, out_wide, out_illegal, out_word[28:0]} ^ 32'h0 | out_word,
        ew);
    if (out_illegal != eill || out_wide != ewide || !out_valid)
      $display("     flags v/ill/wide actual=%0b%0b%0b expected=1%0b%0b",
               out_valid, out_illegal, out_wide, eill, ewide);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not complete");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] ew, pw;
    bit eill, pill, have;
    string tag, ptag;
    logic [31:0] aw, bw;
    bit aill, bill;
    string atag, btag;

    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: empty after reset
    chk(!out_valid && in_ready, "R1 reset state", {30'd0, out_valid, in_ready}, 32'd1);

    // full compressed sweep, upper half driven with junk (R3)
    have = 1'b0;
    pw = '0; pill = 1'b0; ptag = "";
    for (int k = 0; k < 65536; k++) begin
      if ((k & 3) == 3) continue;
      @(negedge clk);
      if (have) chk_out(pw, pill, 1'b0, ptag);
      ref_exp(16'(k), ew, eill, tag);
      in_word  = {16'hA5A5, 16'(k)};
      in_valid = 1'b1;
      pw = ew; pill = eill; ptag = tag; have = 1'b1;
    end
    @(negedge clk);
    chk_out(pw, pill, 1'b0, ptag);

    // R3: full-length words pass unchanged
    have = 1'b0;
    for (int k = 0; k < 256; k++) begin
      @(negedge clk);
      if (have) chk_out(pw, 1'b0, 1'b1, "R3 pass-through");
      pw = (32'h9e37_79b9 * 32'(k)) | 32'h3;
      in_word = pw; have = 1'b1;
    end
    @(negedge clk);
    chk_out(pw, 1'b0, 1'b1, "R3 pass-through");
    in_valid = 1'b0;
    @(negedge clk);
    chk(!out_valid && in_ready, "R2 drains when idle", {30'd0, out_valid, in_ready}, 32'd1);

    // R2: back-pressure holds the word and blocks input
    ref_exp(16'h4495, aw, aill, atag);
    ref_exp(16'h8082, bw, bill, btag);
    in_word = 32'h0000_4495; in_valid = 1'b1; out_ready = 1'b0;
    @(negedge clk);
    chk(!in_ready, "R2 ready low while stalled", {31'd0, in_ready}, 32'd0);
    chk_out(aw, aill, 1'b0, "R2 first word");
    in_word = 32'h0000_8082;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk_out(aw, aill, 1'b0, "R2 hold under stall");
      chk(!in_ready, "R2 ready low while stalled", {31'd0, in_ready}, 32'd0);
    end
    out_ready = 1'b1;
    @(negedge clk);
    chk_out(bw, bill, 1'b0, "R2/R11 second word after release");
    in_valid = 1'b0;
    @(negedge clk);
    chk(!out_valid, "R2 empty after consume", {31'd0, out_valid}, 32'd0);

    // R1: reset mid-stream clears valid
    in_word = 32'h0000_4495; in_valid = 1'b1; out_ready = 1'b0;
    @(negedge clk);
    chk(out_valid, "R2 loaded before reset", {31'd0, out_valid}, 32'd1);
    in_valid = 1'b0; rst = 1'b1;
    @(negedge clk);
    chk(!out_valid && in_ready, "R1 reset mid-stream", {30'd0, out_valid, in_ready}, 32'd1);
    rst = 1'b0; out_ready = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule